// File: doc/BRIEF.md
# Trap Entry Vector Dispatcher

This block turns a raised fault or trap into a change of program flow. Each cycle it looks at a vector of fault requests, one bit per fault class, and picks a single winner by fixed priority. It then loads a new program counter and a next program counter in one clock. The new value is taken from a writable privileged-code base register plus a fixed per-class offset. In the same clock it updates an exception-address register that a handler later uses to return. Whether the current PC is captured depends on a per-class "force save" flag and on whether the processor is already privileged. Trap-type classes, marked by a per-class "skip" flag, move the saved address past the faulting instruction.

A saturating event counter exists for each class and counts the faults that win dispatch. One counter at a time can be read through a select input. The surrounding core holds the pipeline and fetches from `new_pc_o` whenever `valid_o` pulses.

Top module: `trap_dispatch`

## Requirements
- R1: A request seen at a clock edge produces `valid_o` high after that edge, and `new_pc_o` = base + offset of the winning class. Offsets by class index: 0 reset 0x0001, 1 machine check 0x0401, 2 instruction access violation 0x0081, 3 instruction translation miss/page fault 0x0181, 4 single data translation miss 0x0201, 5 double data translation miss 0x0281, 6 unaligned 0x0301, 7 data page fault/access violation 0x0381, 8 illegal opcode 0x0481, 9 arithmetic/overflow 0x0501, 10 float disabled 0x0581, 11 privileged call 0x2001, 12 interrupt 0x0101.
- R2: When several request bits are set, the lowest class index wins, and only that class is dispatched. Reset therefore beats machine check, which beats the memory faults, and interrupt (index 12) is lowest.
- R3: On dispatch, `exc_addr_o` takes `cur_pc` if `force_save[class]` is 1 or `in_priv` is 0. Otherwise it keeps its previous value.
- R4: On dispatch, if `skip_insn[class]` is 1, the exception address resulting from R3 is increased by 4, even when it was not freshly captured.
- R5: `next_pc_o` equals `new_pc_o` + 4 after every dispatch.
- R6: `priv_o` is 1 after a dispatch. In cycles without a dispatch it takes the value `in_priv` had at the previous edge.
- R7: `base_we` loads `base_wdata` into the base register at the edge. A fault dispatched at that same edge uses the previous base.
- R8: Each class counter counts the faults of that class that win dispatch. Requests that lose arbitration are not counted. `cnt_o` shows the counter picked by `cnt_sel` without delay.
- R9: Counters stop at 2^CNT_W-1 and do not wrap.
- R10: After reset, `valid_o`, `new_pc_o`, `next_pc_o`, `exc_addr_o` and all counters are 0, the base is `BASE_RST`, and `priv_o` is 1.
- R11: A cycle without any request leaves `new_pc_o`, `next_pc_o` and `exc_addr_o` unchanged, and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_req | input | 13 | Fault request, one bit per class index |
| cur_pc | input | ADDR_W | PC of the faulting instruction |
| in_priv | input | 1 | Processor already in privileged mode |
| force_save | input | 13 | Per-class flag: always capture the restart address |
| skip_insn | input | 13 | Per-class flag: class is a trap, skip the instruction |
| base_we | input | 1 | Write strobe for the base register |
| base_wdata | input | ADDR_W | New base value |
| cnt_sel | input | 4 | Class index of the counter to read |
| valid_o | output | 1 | One-cycle dispatch pulse |
| new_pc_o | output | ADDR_W | Handler entry PC |
| next_pc_o | output | ADDR_W | Entry PC plus 4 |
| exc_addr_o | output | ADDR_W | Exception (restart) address |
| priv_o | output | 1 | Privileged-mode flag |
| cnt_o | output | CNT_W | Selected class counter |

## Verification
The PC, next-PC, exception address, privilege flag and counters all change at the single edge that samples the request. The bench therefore drives each request on a falling edge and reads every registered result on the following falling edge. It clears the request at that moment, so exactly one dispatch happens. The counter read path has no register: the bench sets `cnt_sel` on a falling edge and samples one time step later. The same-edge base write and the multi-cycle saturation run use this half-cycle discipline as well.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int NCLS  = 13;
    localparam int CLS_W = $clog2(NCLS);
    localparam int VEC_W = 16;
    localparam int INSN_BYTES = 4;

    typedef enum logic [CLS_W-1:0] {
        C_RESET = 4'd0,
        C_MCHK  = 4'd1,
        C_IACV  = 4'd2,
        C_ITBM  = 4'd3,
        C_DTB1  = 4'd4,
        C_DTB2  = 4'd5,
        C_UNAL  = 4'd6,
        C_DFLT  = 4'd7,
        C_OPDEC = 4'd8,
        C_ARITH = 4'd9,
        C_FEN   = 4'd10,
        C_PCALL = 4'd11,
        C_INTR  = 4'd12
    } cls_e;

    function automatic logic [VEC_W-1:0] vec_offset(input logic [CLS_W-1:0] c);
        logic [VEC_W-1:0] v;
        case (c)
            C_RESET: v = 16'h0001;
            C_MCHK:  v = 16'h0401;
            C_IACV:  v = 16'h0081;
            C_ITBM:  v = 16'h0181;
            C_DTB1:  v = 16'h0201;
            C_DTB2:  v = 16'h0281;
            C_UNAL:  v = 16'h0301;
            C_DFLT:  v = 16'h0381;
            C_OPDEC: v = 16'h0481;
            C_ARITH: v = 16'h0501;
            C_FEN:   v = 16'h0581;
            C_PCALL: v = 16'h2001;
            C_INTR:  v = 16'h0101;
            default: v = 16'h0001;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int N = NCLS
) (
    input  logic [N-1:0]            req,
    output logic [N-1:0]            grant,
    output logic [$clog2(N)-1:0]    idx,
    output logic                    any
);
    localparam int IW = $clog2(N);

    logic [N:0] blocked;
    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_prio
        assign grant[i]     = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    assign any = blocked[N];
endmodule

// File: rtl/trap_counters.sv
module trap_counters #(
    parameter int N     = 13,
    parameter int CNT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            hit,
    input  logic [$clog2(N)-1:0]    sel,
    output logic [CNT_W-1:0]        val
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] cnt_d [N];
    logic [CNT_W-1:0] cnt_q [N];

    for (genvar i = 0; i < N; i++) begin : g_cnt
        always_comb begin
            cnt_d[i] = cnt_q[i];
            if (hit[i] && cnt_q[i] != CMAX) cnt_d[i] = cnt_q[i] + 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q[i] <= '0;
            else        cnt_q[i] <= cnt_d[i];
        end
    end

    always_comb begin
        val = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == i[$clog2(N)-1:0]) val = cnt_q[i];
        end
    end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
    import trap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4,
    parameter logic [ADDR_W-1:0] BASE_RST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCLS-1:0]     flt_req,
    input  logic [ADDR_W-1:0]   cur_pc,
    input  logic                in_priv,
    input  logic [NCLS-1:0]     force_save,
    input  logic [NCLS-1:0]     skip_insn,
    input  logic                base_we,
    input  logic [ADDR_W-1:0]   base_wdata,
    input  logic [CLS_W-1:0]    cnt_sel,
    output logic                valid_o,
    output logic [ADDR_W-1:0]   new_pc_o,
    output logic [ADDR_W-1:0]   next_pc_o,
    output logic [ADDR_W-1:0]   exc_addr_o,
    output logic                priv_o,
    output logic [CNT_W-1:0]    cnt_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] npc;
        logic [ADDR_W-1:0] exc;
        logic              valid;
        logic              priv;
    } st_t;

    st_t st_d, st_q;

    logic [NCLS-1:0]  grant_w;
    logic [CLS_W-1:0] win_idx;
    logic             win_any;
    logic [ADDR_W-1:0] entry_w;
    logic [ADDR_W-1:0] exc_sel;

    trap_arbiter #(.N(NCLS)) u_arb (
        .req   (flt_req),
        .grant (grant_w),
        .idx   (win_idx),
        .any   (win_any)
    );

    trap_counters #(.N(NCLS), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (grant_w),
        .sel   (cnt_sel),
        .val   (cnt_o)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.priv  = in_priv;
        entry_w    = st_q.base + {{(ADDR_W-VEC_W){1'b0}}, vec_offset(win_idx)};
        exc_sel    = (force_save[win_idx] || !in_priv) ? cur_pc : st_q.exc;
        if (base_we) st_d.base = base_wdata;
        if (win_any) begin
            st_d.valid = 1'b1;
            st_d.priv  = 1'b1;
            st_d.pc    = entry_w;
            st_d.npc   = entry_w + STEP;
            st_d.exc   = skip_insn[win_idx] ? exc_sel + STEP : exc_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base  <= BASE_RST;
            st_q.pc    <= '0;
            st_q.npc   <= '0;
            st_q.exc   <= '0;
            st_q.valid <= 1'b0;
            st_q.priv  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o    = st_q.valid;
    assign new_pc_o   = st_q.pc;
    assign next_pc_o  = st_q.npc;
    assign exc_addr_o = st_q.exc;
    assign priv_o     = st_q.priv;
endmodule

// File: rtl/trap_dispatch_chk.sv
module trap_dispatch_chk
    import trap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCLS-1:0]   flt_req,
    input logic [NCLS-1:0]   grant_w,
    input logic              valid_o,
    input logic              priv_o,
    input logic [ADDR_W-1:0] new_pc_o,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic [ADDR_W-1:0] exc_addr_o
);
    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (|flt_req) |=> valid_o);  // R1

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_w) && ((|flt_req) == (|grant_w)));  // R2

    AST_NEXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (next_pc_o == new_pc_o + ADDR_W'(4)));  // R5

    AST_PRIV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> priv_o);  // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(|flt_req) |=> (!valid_o && $stable(exc_addr_o) && $stable(new_pc_o)));  // R11
endmodule

bind trap_dispatch trap_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flt_req    (flt_req),
    .grant_w    (grant_w),
    .valid_o    (valid_o),
    .priv_o     (priv_o),
    .new_pc_o   (new_pc_o),
    .next_pc_o  (next_pc_o),
    .exc_addr_o (exc_addr_o)
);

// File: tb/sim_trap_dispatch.sv
`timescale 1ns/1ps
module sim_trap_dispatch;
    localparam int AW = 32;
    localparam int NC = 13;
    localparam int CW = 4;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] flt_req = '0;
    logic [AW-1:0] cur_pc = '0;
    logic          in_priv = 1'b0;
    logic [NC-1:0] force_save;
    logic [NC-1:0] skip_insn;
    logic          base_we = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic [3:0]    cnt_sel = '0;
    logic          valid_o, priv_o;
    logic [AW-1:0] new_pc_o, next_pc_o, exc_addr_o;
    logic [CW-1:0] cnt_o;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    trap_dispatch #(.ADDR_W(AW), .CNT_W(CW), .BASE_RST('0)) u0 (
        .clk(clk), .rst_n(rst_n), .flt_req(flt_req), .cur_pc(cur_pc),
        .in_priv(in_priv), .force_save(force_save), .skip_insn(skip_insn),
        .base_we(base_we), .base_wdata(base_wdata), .cnt_sel(cnt_sel),
        .valid_o(valid_o), .new_pc_o(new_pc_o), .next_pc_o(next_pc_o),
        .exc_addr_o(exc_addr_o), .priv_o(priv_o), .cnt_o(cnt_o)
    );

    // force save: reset(0), machine check(1); skip: arithmetic(9), privileged call(11)
    assign force_save = 13'b0_0000_0000_0011;
    assign skip_insn  = 13'b0_1010_0000_0000;

    // base = 0x8000 for every vector row
    localparam logic [NC-1:0] V_REQ [NV] = '{
        13'h1000, 13'h0800, 13'h0080, 13'h0002,
        13'h1210, 13'h0042, 13'h0200, 13'h1003 };
    localparam logic [AW-1:0] V_PC  [NV] = '{
        32'h1000, 32'h2000, 32'h3000, 32'h4000,
        32'h5000, 32'h6000, 32'h7000, 32'h7100 };
    localparam logic V_PRIV [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [AW-1:0] V_EPC [NV] = '{
        32'h8101, 32'hA001, 32'h8381, 32'h8401,
        32'h8201, 32'h8401, 32'h8501, 32'h8001 };
    localparam logic [AW-1:0] V_EXC [NV] = '{
        32'h1000, 32'h2004, 32'h2004, 32'h4000,
        32'h5000, 32'h6000, 32'h6004, 32'h7100 };
    localparam string V_TAG [NV] = '{
        "R1/R3", "R4", "R3", "R3", "R2", "R2", "R4", "R2" };

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cnt_chk(input int cls, input int exp, input string tag);
        @(negedge clk);
        cnt_sel = 4'(cls);
        #1;
        chk(tag, AW'(cnt_o), AW'(exp));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R10: reset state
        chk("R10 valid", AW'(valid_o), 0);
        chk("R10 pc", new_pc_o, 0);
        chk("R10 exc", exc_addr_o, 0);
        chk("R10 priv", AW'(priv_o), 1);
        chk("R10 cnt", AW'(cnt_o), 0);
        rst_n = 1'b1;

        // R7: base written at the same edge as an interrupt uses the old base (0)
        @(negedge clk);
        base_we = 1'b1; base_wdata = 32'h8000;
        flt_req = 13'h1000; cur_pc = 32'h0900; in_priv = 1'b0;
        @(negedge clk);
        base_we = 1'b0; flt_req = '0;
        chk("R7 old base", new_pc_o, 32'h0101);
        chk("R5 npc", next_pc_o, 32'h0105);
        chk("R3 exc", exc_addr_o, 32'h0900);

        // vector table
        for (int i = 0; i < NV; i++) begin
            flt_req = V_REQ[i]; cur_pc = V_PC[i]; in_priv = V_PRIV[i];
            @(negedge clk);
            flt_req = '0;
            chk({V_TAG[i], " valid"}, AW'(valid_o), 1);
            chk({V_TAG[i], " pc"}, new_pc_o, V_EPC[i]);
            chk("R5 npc", next_pc_o, V_EPC[i] + 4);
            chk({V_TAG[i], " exc"}, exc_addr_o, V_EXC[i]);
            chk("R6 priv", AW'(priv_o), 1);
        end

        // R11: idle cycle holds outputs; R6: priv follows in_priv when idle
        in_priv = 1'b0; cur_pc = 32'hFFFF_0000;
        @(negedge clk);
        chk("R11 valid", AW'(valid_o), 0);
        chk("R11 pc", new_pc_o, 32'h8001);
        chk("R11 exc", exc_addr_o, 32'h7100);
        chk("R6 idle priv", AW'(priv_o), 0);

        // R8: counters count winners only
        cnt_chk(12, 2, "R8 intr");
        cnt_chk(1, 2, "R8 mchk");
        cnt_chk(11, 1, "R8 pcall");
        cnt_chk(4, 1, "R8 dtb1");
        cnt_chk(0, 1, "R8 reset");
        cnt_chk(9, 1, "R8 arith");
        cnt_chk(6, 0, "R8 unal loser");

        // R9: saturation with 20 back-to-back float-disabled faults
        @(negedge clk);
        flt_req = 13'h0400; in_priv = 1'b1;
        repeat (20) @(negedge clk);
        flt_req = '0;
        chk("R1 fen pc", new_pc_o, 32'h8581);
        cnt_chk(10, 15, "R9 saturate");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule